// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

The checker sits beside a bus port and judges every access against a small table of region descriptors. Each descriptor holds a start bound, an end bound, a rights word and a control word. The control word carries a valid flag, a process ID and a process ID mask. Descriptors are loaded through a one-word-per-cycle register write port. For the access currently presented, the checker returns a combinational allow/deny decision and a hit vector with one bit per descriptor.

Rights depend on the class of the requesting master. Low-numbered masters have a user read/write/execute field, a two-bit supervisor code and a process-ID match enable. Higher-numbered masters have only read and write enables.

Descriptor 0 comes out of reset covering the whole address space with full rights for every master. Its bounds cannot be rewritten. Its field for the debug master also cannot be rewritten, so that master never loses access while descriptor 0 is valid. A global enable input bypasses all checking.

Top module: `regprot_checker`

## Requirements
- R1: A region's lower bound is its stored start value with the low GRAN (5) bits forced to zero, so an address just below that 32-byte boundary does not hit.
- R2: A region's upper bound is its stored end value with the low GRAN bits forced to ones, so the last byte of that 32-byte block hits and the next byte does not.
- R3: A descriptor whose valid flag (control word bit 0) is clear never sets its hit bit, whatever its bounds and rights hold.
- R4: Low master m (m < N_LOW) owns rights bits [6m+5:6m]. Its user code is bit 6m+2 read, bit 6m+1 write and bit 6m execute. Its supervisor code at bits [6m+4:6m+3] grants: 00 read/write/execute, 01 read/execute, 10 read/write, 11 the user code. User-mode accesses use the user code.
- R5: High master m (m >= N_LOW) owns two bits at 6*N_LOW + 2(m-N_LOW): the upper bit enables read and the lower bit enables write. Execute is always denied, in either mode.
- R6: After reset, descriptor 0 is valid and spans the entire address space. It gives low masters user code 111 with supervisor code 00, and high masters 11. Writes to its start and end words are ignored. A write to its rights word leaves the DBG_MST field at its reset value.
- R7: Control word bits [15:8] hold the process ID and bits [23:16] hold a mask, where a mask bit of 1 means "ignore this bit". When the requesting low master's enable bit 6m+5 is set, the descriptor hits only if the unmasked bits of the access PID equal those of the stored PID.
- R8: With chk_en low every access is allowed, and the hit vector is still reported.
- R9: With chk_en high an access is allowed exactly when at least one hitting descriptor grants it. Hit bit i belongs to descriptor i, overlapping regions set several bits, and an access with no hit is denied.
- R10: wr_word selects the target word: 0 start, 1 end, 2 rights, 3 control. After reset every descriptor other than 0 is all zero and invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_en | input | 1 | Global checking enable; low allows everything |
| wr_en | input | 1 | Register write strobe |
| wr_desc | input | log2(N_DESC) | Descriptor index written |
| wr_word | input | 2 | Word within the descriptor (0 start, 1 end, 2 rights, 3 control) |
| wr_data | input | 32 | Write data |
| acc_addr | input | AW | Access byte address |
| acc_master | input | log2(N_MST) | Requesting master number |
| acc_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute (3 never granted) |
| acc_pid | input | PID_W | Process ID of the access |
| acc_allow | output | 1 | Access permitted |
| acc_hit | output | N_DESC | Per-descriptor hit vector |

## Verification
The bench uses the default parameters: four descriptors, six masters (four low, two high), the debug master at index 1, 8-bit process IDs with matching enabled, and 32-byte granularity. With these values the bench can cover both master classes. It can also exercise all four supervisor codes and a partially masked PID compare, and build a two-region overlap plus an invalid descriptor spanning the full address range. Because the debug master sits at index 1, a rights write to descriptor 0 can clear its neighbouring fields while the bench checks that the debugger's field survives.

// File: rtl/regprot_pkg.sv
// Shared types and helpers for the region protection checker.
// Assumes the rights layout: 6-bit fields for low masters, 2-bit fields after them.
package regprot_pkg;

    localparam int LOW_FLD_W  = 6;
    localparam int HIGH_FLD_W = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEL_START  = 2'd0,
        SEL_END    = 2'd1,
        SEL_RIGHTS = 2'd2,
        SEL_CTRL   = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rwx_t;

    // Map a supervisor code onto effective rights, falling back to the user code.
    function automatic rwx_t super_rights(input logic [1:0] code, input rwx_t user);
        rwx_t r;
        case (code)
            2'b00:   r = rwx_t'(3'b111);
            2'b01:   r = rwx_t'(3'b101);
            2'b10:   r = rwx_t'(3'b110);
            default: r = user;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/regprot_desc_regs.sv
// Descriptor storage with the write port and the descriptor-0 lock.
// Assumes wr_data is 32 bits, AW <= 32 and PID_W <= 8.
// Start and end keep only the bits above the granule.
module regprot_desc_regs
    import regprot_pkg::*;
#(
    parameter int AW       = 32,
    parameter int GRAN     = 5,
    parameter int N_DESC   = 4,
    parameter int N_MST    = 6,
    parameter int N_LOW    = 4,
    parameter int DBG_MST  = 1,
    parameter int PID_W    = 8,
    localparam int DIDX_W  = (N_DESC > 1) ? $clog2(N_DESC) : 1,
    localparam int RIGHTS_W = N_LOW * LOW_FLD_W + (N_MST - N_LOW) * HIGH_FLD_W,
    localparam int BND_W   = AW - GRAN
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [DIDX_W-1:0]                 wr_desc,
    input  logic [1:0]                        wr_word,
    input  logic [31:0]                       wr_data,
    output logic [N_DESC-1:0][BND_W-1:0]      start_q,
    output logic [N_DESC-1:0][BND_W-1:0]      end_q,
    output logic [N_DESC-1:0][RIGHTS_W-1:0]   rights_q,
    output logic [N_DESC-1:0]                 valid_q,
    output logic [N_DESC-1:0][PID_W-1:0]      pid_q,
    output logic [N_DESC-1:0][PID_W-1:0]      pmask_q
);

    localparam int PID_LSB   = 8;
    localparam int PMASK_LSB = 16;

    // Full rights for every master: user 111 with supervisor 00, or 11 for high masters.
    function automatic logic [RIGHTS_W-1:0] full_rights();
        logic [RIGHTS_W-1:0] r;
        r = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (m < N_LOW) r[m*LOW_FLD_W +: 3] = 3'b111;
            else           r[N_LOW*LOW_FLD_W + (m-N_LOW)*HIGH_FLD_W +: HIGH_FLD_W] = 2'b11;
        end
        return r;
    endfunction

    localparam logic [RIGHTS_W-1:0] RIGHTS0  = full_rights();
    localparam logic [RIGHTS_W-1:0] DBG_MASK =
        RIGHTS_W'({LOW_FLD_W{1'b1}}) << (DBG_MST * LOW_FLD_W);

    logic sel_ok;
    logic sel_zero;

    // Decode whether the addressed descriptor exists and whether it is descriptor 0.
    always_comb begin
        sel_ok   = (int'(wr_desc) < N_DESC);
        sel_zero = (wr_desc == '0);
    end

    // Reset the table and apply writes, honouring the descriptor-0 lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < N_DESC; d++) begin
                start_q[d]  <= '0;
                end_q[d]    <= (d == 0) ? '1 : '0;
                rights_q[d] <= (d == 0) ? RIGHTS0 : '0;
                valid_q[d]  <= (d == 0);
                pid_q[d]    <= '0;
                pmask_q[d]  <= '0;
            end
        end else if (wr_en && sel_ok) begin
            case (word_sel_e'(wr_word))
                SEL_START: if (!sel_zero) start_q[wr_desc] <= wr_data[AW-1:GRAN];
                SEL_END:   if (!sel_zero) end_q[wr_desc]   <= wr_data[AW-1:GRAN];
                SEL_RIGHTS: begin
                    if (sel_zero)
                        rights_q[0] <= (wr_data[RIGHTS_W-1:0] & ~DBG_MASK) | (RIGHTS0 & DBG_MASK);
                    else
                        rights_q[wr_desc] <= wr_data[RIGHTS_W-1:0];
                end
                default: begin
                    valid_q[wr_desc] <= wr_data[0];
                    pid_q[wr_desc]   <= wr_data[PID_LSB +: PID_W];
                    pmask_q[wr_desc] <= wr_data[PMASK_LSB +: PID_W];
                end
            endcase
        end
    end

    // Descriptor-0 bounds never move under a write.
    p_desc0_bounds_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_desc == '0) |=> ($stable(start_q[0]) && $stable(end_q[0])));

    // The debug master's field of descriptor 0 never moves under a write.
    p_desc0_dbg_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_desc == '0) |=> $stable(rights_q[0][DBG_MST*LOW_FLD_W +: LOW_FLD_W]));

endmodule

// File: rtl/regprot_rights.sv
// Rights decoder for one descriptor: picks the requesting master's field and grants by kind.
// Assumes masters at or above N_MST are never granted anything.
module regprot_rights
    import regprot_pkg::*;
#(
    parameter int N_MST   = 6,
    parameter int N_LOW   = 4,
    parameter int HAS_PID = 1,
    localparam int MIDX_W = (N_MST > 1) ? $clog2(N_MST) : 1,
    localparam int RIGHTS_W = N_LOW * LOW_FLD_W + (N_MST - N_LOW) * HIGH_FLD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RIGHTS_W-1:0] rights,
    input  logic [MIDX_W-1:0]   acc_master,
    input  logic                acc_super,
    input  logic [1:0]          acc_kind,
    output logic                grant,
    output logic                pid_en
);

    logic [LOW_FLD_W-1:0]  low_fld;
    logic [HIGH_FLD_W-1:0] high_fld;
    logic                  is_low;
    logic                  is_high;
    rwx_t                  user_r;
    rwx_t                  eff_r;

    // Select the requesting master's field from the rights word.
    always_comb begin
        low_fld  = '0;
        high_fld = '0;
        is_low   = 1'b0;
        is_high  = 1'b0;
        for (int m = 0; m < N_MST; m++) begin
            if (int'(acc_master) == m) begin
                if (m < N_LOW) begin
                    low_fld = rights[m*LOW_FLD_W +: LOW_FLD_W];
                    is_low  = 1'b1;
                end else begin
                    high_fld = rights[N_LOW*LOW_FLD_W + (m-N_LOW)*HIGH_FLD_W +: HIGH_FLD_W];
                    is_high  = 1'b1;
                end
            end
        end
    end

    // Resolve effective rights and grant according to the access kind.
    always_comb begin
        user_r = rwx_t'(low_fld[2:0]);
        eff_r  = acc_super ? super_rights(low_fld[4:3], user_r) : user_r;
        grant  = 1'b0;
        if (is_low) begin
            case (acc_kind_e'(acc_kind))
                ACC_READ:  grant = eff_r.rd;
                ACC_WRITE: grant = eff_r.wr;
                ACC_EXEC:  grant = eff_r.ex;
                default:   grant = 1'b0;
            endcase
        end else if (is_high) begin
            case (acc_kind_e'(acc_kind))
                ACC_READ:  grant = high_fld[1];
                ACC_WRITE: grant = high_fld[0];
                default:   grant = 1'b0;
            endcase
        end
        pid_en = (HAS_PID != 0) && is_low && low_fld[5];
    end

    // High masters can never be granted execute.
    p_high_no_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_master) >= N_LOW && acc_kind == 2'(ACC_EXEC)) |-> !grant);

endmodule

// File: rtl/regprot_match.sv
// Address and process-ID match for one descriptor.
// Assumes the bounds arrive without their granule bits.
module regprot_match #(
    parameter int AW      = 32,
    parameter int GRAN    = 5,
    parameter int PID_W   = 8,
    parameter int HAS_PID = 1,
    localparam int BND_W  = AW - GRAN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BND_W-1:0] reg_start,
    input  logic [BND_W-1:0] reg_end,
    input  logic             reg_valid,
    input  logic [PID_W-1:0] reg_pid,
    input  logic [PID_W-1:0] reg_pmask,
    input  logic [AW-1:0]    acc_addr,
    input  logic [PID_W-1:0] acc_pid,
    input  logic             pid_en,
    output logic             hit
);

    logic [AW-1:0] lo_bound;
    logic [AW-1:0] hi_bound;
    logic          in_range;
    logic          pid_ok;

    // Expand the bounds to full byte addresses and compare inclusively.
    always_comb begin
        lo_bound = {reg_start, {GRAN{1'b0}}};
        hi_bound = {reg_end, {GRAN{1'b1}}};
        in_range = (acc_addr >= lo_bound) && (acc_addr <= hi_bound);
    end

    generate
        if (HAS_PID != 0) begin : g_pid
            // Compare the unmasked PID bits when the master asks for it.
            always_comb pid_ok = !pid_en || (((acc_pid ^ reg_pid) & ~reg_pmask) == '0);
        end else begin : g_nopid
            // No PID feature: every access passes the PID stage.
            always_comb pid_ok = 1'b1;
        end
    endgenerate

    // Combine validity, range and PID stages.
    always_comb hit = reg_valid && in_range && pid_ok;

    // An invalid descriptor never reports a hit.
    p_invalid_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_valid |-> !hit);

endmodule

// File: rtl/regprot_checker.sv
// Top of the region protection checker: descriptor table plus one match and one
// rights decoder per descriptor, reduced to an allow decision.
// Assumes a single access is presented at a time and is judged combinationally.
module regprot_checker
    import regprot_pkg::*;
#(
    parameter int AW       = 32,
    parameter int GRAN     = 5,
    parameter int N_DESC   = 4,
    parameter int N_MST    = 6,
    parameter int N_LOW    = 4,
    parameter int DBG_MST  = 1,
    parameter int PID_W    = 8,
    parameter int HAS_PID  = 1,
    localparam int DIDX_W  = (N_DESC > 1) ? $clog2(N_DESC) : 1,
    localparam int MIDX_W  = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              wr_en,
    input  logic [DIDX_W-1:0] wr_desc,
    input  logic [1:0]        wr_word,
    input  logic [31:0]       wr_data,
    input  logic [AW-1:0]     acc_addr,
    input  logic [MIDX_W-1:0] acc_master,
    input  logic              acc_super,
    input  logic [1:0]        acc_kind,
    input  logic [PID_W-1:0]  acc_pid,
    output logic              acc_allow,
    output logic [N_DESC-1:0] acc_hit
);

    localparam int RIGHTS_W = N_LOW * LOW_FLD_W + (N_MST - N_LOW) * HIGH_FLD_W;
    localparam int BND_W    = AW - GRAN;

    logic [N_DESC-1:0][BND_W-1:0]    start_q;
    logic [N_DESC-1:0][BND_W-1:0]    end_q;
    logic [N_DESC-1:0][RIGHTS_W-1:0] rights_q;
    logic [N_DESC-1:0]               valid_q;
    logic [N_DESC-1:0][PID_W-1:0]    pid_q;
    logic [N_DESC-1:0][PID_W-1:0]    pmask_q;
    logic [N_DESC-1:0]               grant;
    logic [N_DESC-1:0]               pid_en;

    regprot_desc_regs #(
        .AW(AW), .GRAN(GRAN), .N_DESC(N_DESC), .N_MST(N_MST),
        .N_LOW(N_LOW), .DBG_MST(DBG_MST), .PID_W(PID_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_desc(wr_desc),
        .wr_word(wr_word), .wr_data(wr_data), .start_q(start_q), .end_q(end_q),
        .rights_q(rights_q), .valid_q(valid_q), .pid_q(pid_q), .pmask_q(pmask_q)
    );

    generate
        for (genvar d = 0; d < N_DESC; d++) begin : g_desc
            regprot_rights #(
                .N_MST(N_MST), .N_LOW(N_LOW), .HAS_PID(HAS_PID)
            ) u_rights (
                .clk(clk), .rst_n(rst_n), .rights(rights_q[d]),
                .acc_master(acc_master), .acc_super(acc_super), .acc_kind(acc_kind),
                .grant(grant[d]), .pid_en(pid_en[d])
            );

            regprot_match #(
                .AW(AW), .GRAN(GRAN), .PID_W(PID_W), .HAS_PID(HAS_PID)
            ) u_match (
                .clk(clk), .rst_n(rst_n), .reg_start(start_q[d]), .reg_end(end_q[d]),
                .reg_valid(valid_q[d]), .reg_pid(pid_q[d]), .reg_pmask(pmask_q[d]),
                .acc_addr(acc_addr), .acc_pid(acc_pid), .pid_en(pid_en[d]),
                .hit(acc_hit[d])
            );
        end
    endgenerate

    // Allow when checking is off or any hitting descriptor grants the access.
    always_comb acc_allow = !chk_en || |(acc_hit & grant);

    // Checking disabled: nothing is ever denied.
    p_disabled_allows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |-> acc_allow);

    // Checking enabled and no region hit: the access is denied.
    p_no_hit_denies_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && acc_hit == '0) |-> !acc_allow);

endmodule

// File: tb/sim_regprot_checker.sv
// Self-checking bench: directed reset and descriptor-0 tests, a vector table, then enable tests.
module sim_regprot_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_desc = '0;
    logic [1:0]  wr_word = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_master = '0;
    logic        acc_super = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [7:0]  acc_pid = '0;
    logic        acc_allow;
    logic [3:0]  acc_hit;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    regprot_checker u0 (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .wr_en(wr_en), .wr_desc(wr_desc),
        .wr_word(wr_word), .wr_data(wr_data), .acc_addr(acc_addr), .acc_master(acc_master),
        .acc_super(acc_super), .acc_kind(acc_kind), .acc_pid(acc_pid),
        .acc_allow(acc_allow), .acc_hit(acc_hit)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [2:0]  mst;
        logic        sup;
        logic [1:0]  kind;
        logic [7:0]  pid;
        logic        allow;
        logic [3:0]  hit;
        logic [15:0] tag;
    } vec_t;

    // Kind: 0 read, 1 write, 2 execute. Desc1 0x10000000-0x100000FF, desc2 0x10000080-0x100000BF.
    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{32'h1000_0000, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 4'b0010, "R1"},
        '{32'h0FFF_FFFF, 3'd0, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0000, "R1"},
        '{32'h1000_00FF, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 4'b0010, "R2"},
        '{32'h1000_0100, 3'd0, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0000, "R2"},
        '{32'h1000_0040, 3'd0, 1'b0, 2'd1, 8'h00, 1'b0, 4'b0010, "R4"},
        '{32'h1000_0040, 3'd0, 1'b1, 2'd1, 8'h00, 1'b0, 4'b0010, "R4"},
        '{32'h1000_0040, 3'd0, 1'b1, 2'd2, 8'h00, 1'b1, 4'b0010, "R4"},
        '{32'h1000_0040, 3'd0, 1'b0, 2'd2, 8'h00, 1'b0, 4'b0010, "R4"},
        '{32'h1000_0040, 3'd2, 1'b1, 2'd1, 8'h53, 1'b1, 4'b0010, "R7"},
        '{32'h1000_0040, 3'd2, 1'b1, 2'd1, 8'h6A, 1'b0, 4'b0000, "R7"},
        '{32'h1000_0040, 3'd2, 1'b0, 2'd2, 8'h5F, 1'b0, 4'b0010, "R4"},
        '{32'h1000_0040, 3'd4, 1'b0, 2'd0, 8'h00, 1'b1, 4'b0010, "R5"},
        '{32'h1000_0040, 3'd4, 1'b0, 2'd1, 8'h00, 1'b0, 4'b0010, "R5"},
        '{32'h1000_0040, 3'd4, 1'b1, 2'd2, 8'h00, 1'b0, 4'b0010, "R5"},
        '{32'h1000_0040, 3'd5, 1'b0, 2'd1, 8'h00, 1'b1, 4'b0010, "R5"},
        '{32'h1000_0040, 3'd5, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0010, "R5"},
        '{32'h1000_0040, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0010, "R9"},
        '{32'h1000_00A0, 3'd0, 1'b0, 2'd1, 8'h00, 1'b1, 4'b0110, "R9"},
        '{32'h1000_00A0, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 4'b0110, "R9"},
        '{32'h2000_0000, 3'd0, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0000, "R3"},
        '{32'h1000_00C0, 3'd0, 1'b0, 2'd1, 8'h00, 1'b0, 4'b0010, "R9"}
    };

    // One register write, captured at the posedge between two falling edges.
    task automatic wr(input logic [1:0] d, input logic [1:0] w, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_desc = d; wr_word = w; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Present one access, let the combinational result settle, compare.
    task automatic chk(input logic [31:0] a, input logic [2:0] m, input logic s,
                       input logic [1:0] k, input logic [7:0] p,
                       input logic ea, input logic [3:0] eh, input string tag);
        @(negedge clk);
        acc_addr = a; acc_master = m; acc_super = s; acc_kind = k; acc_pid = p;
        #1;
        n_chk++;
        if (acc_allow !== ea || acc_hit !== eh) begin
            n_err++;
            $display("FAIL %s addr=%h mst=%0d: allow=%b hit=%b expected allow=%b hit=%b",
                     tag, a, m, acc_allow, acc_hit, ea, eh);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 R6: reset state, only descriptor 0 valid, full range and full rights
        chk(32'h0000_0000, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 4'b0001, "R10");
        chk(32'hFFFF_FFFF, 3'd5, 1'b0, 2'd1, 8'h00, 1'b1, 4'b0001, "R6");
        chk(32'h1234_5678, 3'd0, 1'b1, 2'd2, 8'h00, 1'b1, 4'b0001, "R6");

        // R6: descriptor 0 bounds locked, debug master field kept
        wr(2'd0, 2'd0, 32'h8000_0000);
        wr(2'd0, 2'd1, 32'h0000_0000);
        wr(2'd0, 2'd2, 32'h0000_0000);
        chk(32'hFFFF_FFE0, 3'd0, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0001, "R6");
        chk(32'h0000_0000, 3'd1, 1'b0, 2'd0, 8'h00, 1'b1, 4'b0001, "R6");
        chk(32'h0000_0000, 3'd1, 1'b1, 2'd1, 8'h00, 1'b1, 4'b0001, "R6");
        chk(32'h4000_0000, 3'd4, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0001, "R6");

        // R3: invalidate descriptor 0
        wr(2'd0, 2'd3, 32'h0000_0000);
        chk(32'h0000_0000, 3'd1, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0000, "R3");

        // Descriptor 1: unaligned bounds, mixed rights, PID 0x5A with low nibble masked
        wr(2'd1, 2'd0, 32'h1000_0013);
        wr(2'd1, 2'd1, 32'h1000_00E0);
        wr(2'd1, 2'd2, 32'h0603_E00C);
        wr(2'd1, 2'd3, 32'h000F_5A01);
        // Descriptor 2: overlap, master 0 user write only
        wr(2'd2, 2'd0, 32'h1000_0080);
        wr(2'd2, 2'd1, 32'h1000_00BF);
        wr(2'd2, 2'd2, 32'h0000_0002);
        wr(2'd2, 2'd3, 32'h0000_0001);
        // Descriptor 3: full range, full rights, but left invalid
        wr(2'd3, 2'd0, 32'h0000_0000);
        wr(2'd3, 2'd1, 32'hFFFF_FFFF);
        wr(2'd3, 2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 2'd3, 32'h0000_0000);

        for (int i = 0; i < NV; i++) begin
            chk(TBL[i].addr, TBL[i].mst, TBL[i].sup, TBL[i].kind, TBL[i].pid,
                TBL[i].allow, TBL[i].hit, $sformatf("%s row %0d", TBL[i].tag, i));
        end

        // R8: global enable off allows everything, hit vector still reported
        chk_en = 1'b0;
        chk(32'h0FFF_FFFF, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 4'b0000, "R8");
        chk(32'h1000_0040, 3'd0, 1'b0, 2'd1, 8'h00, 1'b1, 4'b0010, "R8");
        chk(32'h1000_0040, 3'd4, 1'b0, 2'd2, 8'h00, 1'b1, 4'b0010, "R8");
        chk_en = 1'b1;
        chk(32'h1000_0040, 3'd4, 1'b0, 2'd2, 8'h00, 1'b0, 4'b0010, "R8");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule